// File: doc/BRIEF.md
# Reset Supervisor with Qualified Manual Reset

This block generates one active-low, push-pull reset level for the rest of a chip from two causes. The first is a digital power-good level from an external supply comparator. The second is an active-low manual-reset request that idles high. Reset is driven while power is not good. Once power is good, reset stays asserted for a fixed recovery interval so the supply can settle.

The manual request passes through a synchronizer and a pulse-width qualifier. A low pulse that lasts long enough starts the same recovery sequence as a power cycle and gives exactly the same hold duration, because both causes drive one shared recovery counter. Shorter pulses are treated as noise and have no effect. Any new cause that arrives during the hold restarts the count. The output is released only after one full, uninterrupted interval in which power is good and no qualified manual request is active.

All times are parameters in clock cycles. The qualification width `MIN_PULSE_CYC` should be chosen so that 200 ns or more of low time always qualifies, while anything under 50 ns never does. The recovery length `REC_CYC` must give a delay between 40 ms and 200 ms at the clock in use. At 250 MHz, for example, the delay in milliseconds is REC_CYC / 250000, so REC_CYC = 25000000 gives 100 ms. The block is reset by `arst_n`, an asynchronous register reset, and it leaves that reset with its output asserted.

Top module: `rst_supervisor`

## Requirements
- R1: While `pwr_good_i` is low at a rising clock edge, `rst_n_o` is 0 after that edge, and it stays 0 as long as `pwr_good_i` stays low.
- R2: While `arst_n` is low, `rst_n_o` is 0. After `arst_n` is released, `rst_n_o` stays 0 for as long as `pwr_good_i` stays low.
- R3: With `mr_n_i` high, `rst_n_o` goes to 1 right after the REC_CYC-th rising edge, counting from the first edge that samples `pwr_good_i` high. Before that edge it is 0.
- R4: A low pulse on `mr_n_i` that spans L >= MIN_PULSE_CYC rising edges asserts reset. `rst_n_o` is 0 from edge MIN_PULSE_CYC+3 onward, counting the first edge that samples the pulse low as edge 1.
- R5: A low pulse on `mr_n_i` that spans fewer than MIN_PULSE_CYC edges never changes `rst_n_o`.
- R6: After a qualified pulse, `rst_n_o` goes to 1 right after the (REC_CYC+3)-th edge that samples `mr_n_i` high again. This is the same recovery count that a power-good rise uses, plus the 3-edge input pipeline.
- R7: With `pwr_good_i` and `mr_n_i` both held high and the output released, `rst_n_o` stays 1 indefinitely.
- R8: If `pwr_good_i` drops during the recovery hold, the count restarts. Release happens REC_CYC edges after power-good becomes high again.
- R9: A qualified manual pulse during a power-good hold, including one that qualifies on the same edge as power-good returns, moves the release to REC_CYC+3 edges after `mr_n_i` returns high.
- R10: A short manual pulse (fewer than MIN_PULSE_CYC edges low) during a hold does not move the release edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous register reset, active low |
| pwr_good_i | input | 1 | Supply-good level from the comparator, synchronous to clk |
| mr_n_i | input | 1 | Manual reset request, active low, asynchronous, idles high |
| rst_n_o | output | 1 | Generated reset, active low |

## Verification
Power-good recovery and manual-reset qualification both act on the one recovery counter, and they can hit it on the same edge. The bench provokes this by holding power-good low while the manual input is low. It then raises power-good on exactly the edge where the qualifier saturates. The outcome is judged against an arithmetic release edge: the release must follow the manual rise by REC_CYC+3 edges, not the earlier power-good release point. Pulse widths around the qualification threshold are swept one cycle at a time, and each sweep checks the assert and release edges cycle by cycle.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;

    // Width of a counter that must be able to hold the value 'limit'.
    function automatic int cnt_bits(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    typedef enum logic {
        RST_ASSERTED = 1'b0,
        RST_RELEASED = 1'b1
    } rst_lvl_e;

endpackage

// File: rtl/mr_sync.sv
module mr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic async_n_i,
    output logic sync_n_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], async_n_i};
    end

    // Reset value is the idle-high level, so an undriven input never requests reset.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '1;
        else         sh_q <= sh_d;
    end

    assign sync_n_o = sh_q[STAGES-1];

endmodule

// File: rtl/mr_qualify.sv
module mr_qualify
    import rst_sup_pkg::*;
#(
    parameter int MIN_PULSE_CYC = 50
) (
    input  logic clk,
    input  logic arst_n,
    input  logic sync_n_i,
    output logic hold_o
);
    localparam int        W     = cnt_bits(MIN_PULSE_CYC);
    localparam logic [W-1:0] LIMIT = W'(MIN_PULSE_CYC);

    typedef struct packed {
        logic [W-1:0] low_cnt;
    } qual_t;

    qual_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (sync_n_i) begin
            nxt_d.low_cnt = '0;
        end else if (cur_q.low_cnt != LIMIT) begin
            nxt_d.low_cnt = cur_q.low_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) cur_q <= '0;
        else         cur_q <= nxt_d;
    end

    // Saturated count: the pulse has qualified and is still low.
    assign hold_o = (cur_q.low_cnt == LIMIT);

    a_r5_count_capped: assert property (@(posedge clk) disable iff (!arst_n)
        cur_q.low_cnt <= LIMIT);

    a_r4_hold_after_low: assert property (@(posedge clk) disable iff (!arst_n)
        hold_o |-> !$past(sync_n_i));

endmodule

// File: rtl/hold_timer.sv
module hold_timer
    import rst_sup_pkg::*;
#(
    parameter int REC_CYC = 25_000_000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pg_i,
    input  logic mr_hold_i,
    output logic rst_n_o
);
    localparam int        W    = cnt_bits(REC_CYC);
    localparam logic [W-1:0] LAST = W'(REC_CYC - 1);

    typedef struct packed {
        rst_lvl_e     lvl;
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!pg_i || mr_hold_i) begin
            nxt_d.lvl = RST_ASSERTED;
            nxt_d.cnt = '0;
        end else if (cur_q.lvl == RST_ASSERTED) begin
            if (cur_q.cnt == LAST) begin
                nxt_d.lvl = RST_RELEASED;
                nxt_d.cnt = '0;
            end else begin
                nxt_d.cnt = cur_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cur_q.lvl <= RST_ASSERTED;
            cur_q.cnt <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rst_n_o = cur_q.lvl;

    a_r1_pg_loss_asserts: assert property (@(posedge clk) disable iff (!arst_n)
        !pg_i |=> !rst_n_o);

    a_r8_release_only_when_quiet: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(rst_n_o) |-> ($past(pg_i) && !$past(mr_hold_i)));

    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!arst_n)
        cur_q.cnt <= LAST);

    a_r7_stays_released: assert property (@(posedge clk) disable iff (!arst_n)
        (rst_n_o && pg_i && !mr_hold_i) |=> rst_n_o);

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int MIN_PULSE_CYC = 50,
    parameter int REC_CYC       = 25_000_000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pwr_good_i,
    input  logic mr_n_i,
    output logic rst_n_o
);
    logic mr_sync_n;
    logic mr_hold;

    mr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .arst_n    (arst_n),
        .async_n_i (mr_n_i),
        .sync_n_o  (mr_sync_n)
    );

    mr_qualify #(.MIN_PULSE_CYC(MIN_PULSE_CYC)) u_qual (
        .clk      (clk),
        .arst_n   (arst_n),
        .sync_n_i (mr_sync_n),
        .hold_o   (mr_hold)
    );

    // One shared counter gives both causes the same recovery length.
    hold_timer #(.REC_CYC(REC_CYC)) u_tmr (
        .clk       (clk),
        .arst_n    (arst_n),
        .pg_i      (pwr_good_i),
        .mr_hold_i (mr_hold),
        .rst_n_o   (rst_n_o)
    );

    a_r9_hold_forces_reset: assert property (@(posedge clk) disable iff (!arst_n)
        mr_hold |=> !rst_n_o);

endmodule

// File: tb/rst_supervisor_test.sv
`timescale 1ns/1ps
module rst_supervisor_test;
    localparam int MINP = 4;
    localparam int REC  = 10;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic pg = 1'b0;
    logic mr_n = 1'b1;
    logic rst_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rst_supervisor #(.MIN_PULSE_CYC(MINP), .REC_CYC(REC)) uut (
        .clk        (clk),
        .arst_n     (arst_n),
        .pwr_good_i (pg),
        .mr_n_i     (mr_n),
        .rst_n_o    (rst_n)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rst_n_o=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // pg was just raised after a tick: release right after the REC-th edge.
    task automatic pg_release(input string req);
        for (int i = 1; i <= REC + 2; i++) begin
            tick();
            check(rst_n, logic'(i >= REC), req);
        end
    endtask

    // Manual pulse of L edges starting from the released state.
    task automatic mr_sweep(input int len);
        mr_n = 1'b0;
        for (int t = 1; t <= len + REC + 6; t++) begin
            tick();
            if (len >= MINP)
                check(rst_n, logic'(!(t >= MINP + 3 && t < len + REC + 3)),
                      (t < len + 3) ? "R4" : "R6");
            else
                check(rst_n, 1'b1, "R5");
            if (t == len) mr_n = 1'b1;
        end
    endtask

    initial begin
        #1;
        check(rst_n, 1'b0, "R2");
        tick(); tick();
        check(rst_n, 1'b0, "R2");
        arst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            check(rst_n, 1'b0, "R2");
        end
        pg = 1'b1;
        pg_release("R3");

        // R7: idle inputs keep the output released
        for (int i = 0; i < 40; i++) begin
            tick();
            check(rst_n, 1'b1, "R7");
        end

        // R4, R5, R6: pulse width sweep around the threshold
        for (int len = 1; len <= MINP + 4; len++) mr_sweep(len);

        // R1 and R8: power loss, then a glitch in the middle of the hold
        pg = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            check(rst_n, 1'b0, "R1");
        end
        pg = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick();
            check(rst_n, 1'b0, "R8");
        end
        pg = 1'b0;
        tick();
        check(rst_n, 1'b0, "R1");
        pg = 1'b1;
        pg_release("R8");

        // R9: qualified manual pulse during a power-good hold
        pg = 1'b0;
        tick();
        pg = 1'b1;
        for (int t = 1; t <= (MINP + 1) + REC + 8; t++) begin
            tick();
            check(rst_n, logic'(t >= (MINP + 1) + REC + 5), "R9");
            if (t == 2) mr_n = 1'b0;
            if (t == 2 + MINP + 1) mr_n = 1'b1;
        end

        // R10: short pulse during a hold leaves the release edge alone
        pg = 1'b0;
        tick();
        pg = 1'b1;
        for (int t = 1; t <= REC + 4; t++) begin
            tick();
            check(rst_n, logic'(t >= REC), "R10");
            if (t == 2) mr_n = 1'b0;
            if (t == 2 + MINP - 1) mr_n = 1'b1;
        end

        // R9 collision: pg returns on the edge where the qualifier saturates
        pg = 1'b0;
        tick();
        mr_n = 1'b0;
        for (int t = 1; t <= (MINP + 2) + REC + 6; t++) begin
            tick();
            check(rst_n, logic'(t >= (MINP + 2) + REC + 3), "R9");
            if (t == MINP + 2) pg = 1'b1;
            if (t == MINP + 2) mr_n = 1'b1;
        end

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule